// File: doc/BRIEF.md
# Single-Upset-Correcting Sequencer State Machine

This block is a four-state control sequencer (idle, request, transfer, done) whose state register holds five-bit codes that differ from one another in at least three bit positions. Each cycle, the stored word is matched to the one valid code that lies within one bit of it. That corrected state drives the outputs and the next-state logic, and the clean code is written back on the next edge. A single flipped bit in the register therefore never shows on the outputs, never causes a transition outside the diagram, and never resets the machine.

A word that lies two or more bits from every valid code cannot be repaired. The machine then shows idle, moves to idle on the next edge whatever the inputs are, and raises a flag that stays high until reset. A fault-injection mask input is XORed into the word on every register write. This lets upsets be provoked through the normal interface. When the mask is zero it has no effect.

Top module: `upset_safe_seq`

## Requirements
- R1: The codes, written as bit 4 down to bit 0, are idle 00000, request 00111, transfer 11001 and done 11110, and every pair differs in at least 3 bits. While `rst_n` is low and after its release, the register holds the idle code, `idle_o`=1, `fix_o`=0 and `fatal_o`=0.
- R2: Without upsets, idle goes to request when `start_i`=1, request goes to transfer when `grant_i`=1, transfer goes to done when `last_i`=1, and done goes to idle after one cycle. Any other input combination holds the state. An input that has no role in the present state is ignored.
- R3: Exactly one of `idle_o`, `req_o`, `xfer_o`, `done_o` is high in every cycle. It names the corrected state, or idle when the word is uncorrectable.
- R4: A register word one bit from a valid code is treated as that code for both outputs and transition, and on the next edge the register takes the clean successor code.
- R5: `fix_o` is high in exactly those cycles in which the register word is one bit away from a valid code.
- R6: A register word at least two bits from every valid code shows idle on the outputs, keeps `fix_o` low, and leads to idle on the next edge regardless of the inputs.
- R7: `fatal_o` goes high on the edge after an uncorrectable word is held, and stays high until `rst_n` is asserted.
- R8: On each clock edge the register loads the next state's code XOR `flip_mask_i`. An all-zero mask leaves the loaded code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sequence from idle |
| grant_i | input | 1 | Request accepted, move to transfer |
| last_i | input | 1 | Final beat of transfer |
| flip_mask_i | input | 5 | Bits to invert in the word written on the next edge |
| idle_o | output | 1 | Corrected state is idle (or word uncorrectable) |
| req_o | output | 1 | Corrected state is request |
| xfer_o | output | 1 | Corrected state is transfer |
| done_o | output | 1 | Corrected state is done |
| fix_o | output | 1 | A single-bit correction is being made this cycle |
| fatal_o | output | 1 | Sticky: an uncorrectable word has been seen |

## Verification
A correction and a legal transition can fall in the same cycle. This happens when the register holds a word with one bit flipped while the input that advances the corrected state is high. The bench provokes it by loading a single-bit mask on the edge that enters a state, then driving that state's advance input in the following cycle. The behavioural model expects `fix_o` high together with the current state's output, then the successor state's output with `fix_o` low. A second overlap is an uncorrectable word that meets an asserted `start_i`; the model expects idle to be kept and `fatal_o` to rise.

// File: rtl/upset_seq_pkg.sv
`timescale 1ns/1ps
package upset_seq_pkg;
  localparam int CODE_W  = 5;
  localparam int N_STATE = 4;
  localparam int SEL_W   = $clog2(N_STATE);

  typedef enum logic [SEL_W-1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_XFER = 2'd2,
    S_DONE = 2'd3
  } seq_state_e;

  typedef logic [CODE_W-1:0] code_t;

  // codeword of each state; pairwise distance >= 3
  function automatic code_t code_of(seq_state_e s);
    case (s)
      S_IDLE:  return 5'b00000;
      S_REQ:   return 5'b00111;
      S_XFER:  return 5'b11001;
      default: return 5'b11110;
    endcase
  endfunction

  // number of differing bit positions
  function automatic int bit_distance(code_t a, code_t b);
    int n;
    code_t d;
    n = 0;
    d = a ^ b;
    for (int i = 0; i < CODE_W; i++) n += int'(d[i]);
    return n;
  endfunction
endpackage

// File: rtl/seq_code_decode.sv
`timescale 1ns/1ps
module seq_code_decode
  import upset_seq_pkg::*;
(
  input  code_t      raw_i,
  output seq_state_e state_o,
  output logic       fixed_o,
  output logic       bad_o
);
  logic [N_STATE-1:0] near;
  logic [N_STATE-1:0] exact;

  for (genvar g = 0; g < N_STATE; g++) begin : g_cmp
    assign near[g]  = bit_distance(raw_i, code_of(seq_state_e'(g))) <= 1;
    assign exact[g] = raw_i == code_of(seq_state_e'(g));
  end

  always_comb begin
    state_o = S_IDLE;
    for (int i = 0; i < N_STATE; i++)
      if (near[i]) state_o = seq_state_e'(i);
  end

  assign fixed_o = (|near) & ~(|exact);
  assign bad_o   = ~(|near);
endmodule

// File: rtl/seq_next_state.sv
`timescale 1ns/1ps
module seq_next_state
  import upset_seq_pkg::*;
(
  input  seq_state_e cur_i,
  input  logic       bad_i,
  input  logic       start_i,
  input  logic       grant_i,
  input  logic       last_i,
  output seq_state_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (bad_i) begin
      nxt_o = S_IDLE;
    end else begin
      case (cur_i)
        S_IDLE:  if (start_i) nxt_o = S_REQ;
        S_REQ:   if (grant_i) nxt_o = S_XFER;
        S_XFER:  if (last_i)  nxt_o = S_DONE;
        default: nxt_o = S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seq_out_decode.sv
`timescale 1ns/1ps
module seq_out_decode
  import upset_seq_pkg::*;
(
  input  seq_state_e         cur_i,
  output logic [N_STATE-1:0] sel_o
);
  for (genvar g = 0; g < N_STATE; g++) begin : g_sel
    assign sel_o[g] = cur_i == seq_state_e'(g);
  end
endmodule

// File: rtl/upset_safe_seq.sv
`timescale 1ns/1ps
module upset_safe_seq
  import upset_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              grant_i,
  input  logic              last_i,
  input  logic [CODE_W-1:0] flip_mask_i,
  output logic              idle_o,
  output logic              req_o,
  output logic              xfer_o,
  output logic              done_o,
  output logic              fix_o,
  output logic              fatal_o
);
  code_t              word_q;
  logic               fatal_q;
  seq_state_e         cur_st;
  seq_state_e         nxt_st;
  logic               fixed_w;
  logic               bad_word;
  logic [N_STATE-1:0] sel;

  seq_code_decode u_dec (
    .raw_i   (word_q),
    .state_o (cur_st),
    .fixed_o (fixed_w),
    .bad_o   (bad_word)
  );

  seq_next_state u_nxt (
    .cur_i   (cur_st),
    .bad_i   (bad_word),
    .start_i (start_i),
    .grant_i (grant_i),
    .last_i  (last_i),
    .nxt_o   (nxt_st)
  );

  seq_out_decode u_out (
    .cur_i (cur_st),
    .sel_o (sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= code_of(S_IDLE);
      fatal_q <= 1'b0;
    end else begin
      word_q  <= code_of(nxt_st) ^ flip_mask_i;
      fatal_q <= fatal_q | bad_word;
    end
  end

  assign idle_o  = sel[S_IDLE];
  assign req_o   = sel[S_REQ];
  assign xfer_o  = sel[S_XFER];
  assign done_o  = sel[S_DONE];
  assign fix_o   = fixed_w;
  assign fatal_o = fatal_q;
endmodule

// File: rtl/upset_safe_seq_chk.sv
`timescale 1ns/1ps
module upset_safe_seq_chk
  import upset_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              grant_i,
  input logic [CODE_W-1:0] flip_mask_i,
  input logic              idle_o,
  input logic              req_o,
  input logic              xfer_o,
  input logic              done_o,
  input logic              fix_o,
  input logic              fatal_o,
  input logic              bad_word
);
  // R3
  onehot_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({idle_o, req_o, xfer_o, done_o}) == 1);

  // R6
  bad_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_word && flip_mask_i == '0) |=> (idle_o && !fix_o));

  // R7
  fatal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_word |=> fatal_o);

  // R7
  fatal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |=> fatal_o);

  // R5
  fix_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_o |-> !bad_word);

  // R4
  clean_after_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_o && flip_mask_i == '0) |=> (!fix_o && !bad_word));

  // R2
  req_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && $countones(flip_mask_i) <= 1) |=> (req_o || xfer_o));

  // R2
  done_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $countones(flip_mask_i) <= 1) |=> idle_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && !start_i && $countones(flip_mask_i) <= 1) |=> idle_o);

  // R2
  grant_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && grant_i && $countones(flip_mask_i) <= 1) |=> xfer_o);
endmodule

bind upset_safe_seq upset_safe_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .grant_i     (grant_i),
  .flip_mask_i (flip_mask_i),
  .idle_o      (idle_o),
  .req_o       (req_o),
  .xfer_o      (xfer_o),
  .done_o      (done_o),
  .fix_o       (fix_o),
  .fatal_o     (fatal_o),
  .bad_word    (bad_word)
);

// File: tb/tb_upset_safe_seq.sv
`timescale 1ns/1ps
module tb_upset_safe_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, grant_i = 1'b0, last_i = 1'b0;
  logic [4:0] flip_mask_i = '0;
  logic       idle_o, req_o, xfer_o, done_o, fix_o, fatal_o;

  int n_chk = 0;
  int n_bad = 0;
  string phase = "R1";

  // behavioural model: stored word and sticky flag
  logic [4:0] m_word = 5'b00000;
  logic       m_fatal = 1'b0;
  logic [4:0] m_code [4] = '{5'b00000, 5'b00111, 5'b11001, 5'b11110};
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  upset_safe_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .grant_i(grant_i),
    .last_i(last_i), .flip_mask_i(flip_mask_i), .idle_o(idle_o),
    .req_o(req_o), .xfer_o(xfer_o), .done_o(done_o), .fix_o(fix_o),
    .fatal_o(fatal_o)
  );

  function automatic int nearest(logic [4:0] w);
    int r;
    r = -1;
    foreach (m_code[k]) if ($countones(w ^ m_code[k]) <= 1) r = k;
    return r;
  endfunction

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b (word model %b)", tag, what, act, exp, m_word);
    end
  endtask

  task automatic compare();
    int k;
    k = nearest(m_word);
    check(phase, "idle_o", idle_o, (k == 0) || (k < 0));
    check(phase, "req_o",  req_o,  k == 1);
    check(phase, "xfer_o", xfer_o, k == 2);
    check(phase, "done_o", done_o, k == 3);
    check("R5", "fix_o", fix_o, (k >= 0) && (m_word != m_code[k]));
    check("R7", "fatal_o", fatal_o, m_fatal);
  endtask

  task automatic step(logic s, logic g, logic l, logic [4:0] m);
    int k, nx;
    @(negedge clk);
    compare();
    start_i = s; grant_i = g; last_i = l; flip_mask_i = m;
    k = nearest(m_word);
    if (k < 0) nx = 0;
    else if (k == 0) nx = s ? 1 : 0;
    else if (k == 1) nx = g ? 2 : 1;
    else if (k == 2) nx = l ? 3 : 2;
    else nx = 0;
    @(posedge clk);
    if (k < 0) m_fatal = 1'b1;
    m_word = m_code[nx] ^ m;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start_i = 0; grant_i = 0; last_i = 0; flip_mask_i = '0;
    m_word = 5'b00000; m_fatal = 1'b0;
    #1;
    phase = "R1";
    compare();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    // R1: reset state
    #2;
    compare();
    do_reset();

    // R2: plain walk, with inputs that play no role asserted
    phase = "R2";
    step(0, 1, 1, '0);  // idle ignores grant/last
    step(1, 0, 0, '0);  // -> req
    step(1, 0, 1, '0);  // req ignores start/last
    step(0, 1, 0, '0);  // -> xfer
    step(1, 1, 0, '0);  // hold
    step(0, 0, 1, '0);  // -> done
    step(0, 0, 0, '0);  // -> idle
    step(0, 0, 0, '0);

    // R4: correction and transition in the same cycle, directed
    phase = "R4";
    step(1, 0, 0, 5'b00010);  // enter req with one flipped bit
    step(0, 1, 0, '0);        // corrected req advances to xfer
    step(0, 0, 0, 5'b10000);  // xfer held, flipped
    step(0, 0, 1, '0);        // corrected xfer -> done
    step(0, 0, 0, 5'b00001);  // done -> idle, flipped
    step(0, 0, 0, '0);

    // R8: zero mask leaves the code as written (checked by outputs and fix_o)
    phase = "R8";
    for (int i = 0; i < 8; i++) step(i[0], i[1], i[2], '0);

    // R4: pseudo-random walk with single-bit upsets
    phase = "R4";
    for (int i = 0; i < 400; i++) begin
      r = rnd();
      step(r[0], r[1], r[2], (r[5:4] == 2'b00) ? (5'b00001 << (r[10:8] % 5)) : 5'b00000);
    end

    // R6: uncorrectable word meeting start, directed
    phase = "R6";
    step(0, 0, 0, 5'b00011);  // idle code with two bits inverted
    step(1, 1, 1, '0);        // must go to idle despite start
    step(0, 0, 0, '0);

    // R6: random double-bit upsets
    for (int i = 0; i < 200; i++) begin
      r = rnd();
      step(r[0], r[1], r[2], (r[6:4] == 3'b000) ? 5'b00101 << (r[9:8] % 3) : 5'b00000);
    end

    // R7: flag stays until reset, then clears
    phase = "R7";
    step(0, 0, 0, '0);
    check("R7", "fatal_o sticky", fatal_o, 1'b1);
    do_reset();
    check("R7", "fatal_o after reset", fatal_o, 1'b0);
    phase = "R2";
    step(1, 0, 0, '0);
    step(0, 0, 0, '0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule